// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block sits between a 32-bit word-addressed register bus and the bit engine of a FIFO-based I2C master. It owns two small FIFOs. The command FIFO holds transfer words written by software and offered to the engine. The receive FIFO holds bytes pushed by the engine and popped by software reads. The block also holds the control fields, the three bus timing counts and the interrupt enable mask.

Two status conditions are live comparisons between a FIFO level and a programmable threshold: space available for commands, and data waiting to be read. Three more are sticky event flags for a missing acknowledge, lost arbitration and receive overrun, and software clears these by writing ones. A single level interrupt is raised whenever an enabled status bit is set. The engine sees a valid/pop pair on the command side and a push port on the receive side, plus event pulses and a busy input.

Top module: `i2cm_csr_front`

## Requirements
- R1: After reset the control, enable-mask and timing registers read 0, the interrupt line is low, no command is offered, and the status register reads 0x01, because an empty command FIFO meets the threshold.
- R2: Control (word 2: bit 0 enable, bit 1 fast mode, bits 3:2 command threshold, bits 5:4 receive threshold), enable mask (word 3, 5 bits), SCL low (word 8), SCL high (word 9) and SDA hold (word 10, each CNT_W bits) read back what was written, truncated to their widths, and drive the matching output ports.
- R3: A write to word 0 pushes bits 9:0 (bit 9 start, bit 8 stop, bits 7:0 data) into the command FIFO. The engine sees the oldest entry on `cmd_word` with `cmd_valid` high and removes it with `cmd_pop`. Word 6 reads the command FIFO level.
- R4: A command write while the command FIFO holds DEPTH entries is dropped, and the level and stored order are unchanged.
- R5: `rx_push` stores `rx_byte` in the receive FIFO. A read of word 1 returns the oldest byte in bits 7:0 and removes it. Word 7 reads the receive FIFO level.
- R6: A read of word 1 with the receive FIFO empty returns 0 and leaves the level at 0.
- R7: An `rx_push` while the receive FIFO is full discards the byte and sets status bit 4 (overrun).
- R8: Status bit 0 (command room) is high exactly while the command FIFO level is less than or equal to the command threshold.
- R9: Status bit 1 (data waiting) is high exactly while the receive FIFO level is greater than the receive threshold, so threshold 0 fires at one entry. Writing 1 to this bit does not clear it.
- R10: Status bit 2 (no acknowledge) and bit 3 (arbitration lost) are set by one-cycle pulses on `ev_nack` and `ev_arb`. They stay set after the pulse and are cleared only by writing 1 to word 4. An event in the same cycle as its clear leaves the bit set.
- R11: `irq` is high exactly when some status bit and the same enable-mask bit are both 1.
- R12: A control write that changes bit 0 from 1 to 0 empties both FIFOs.
- R13: Word 5 bit 0 reads the `core_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the receive data word) |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Command FIFO not empty |
| cmd_word | output | 10 | Oldest command entry |
| cmd_pop | input | 1 | Engine takes the oldest command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_nack | input | 1 | Missing-acknowledge event pulse |
| ev_arb | input | 1 | Arbitration-lost event pulse |
| core_busy | input | 1 | Engine busy indication |
| core_en | output | 1 | Control enable bit |
| fast_mode | output | 1 | Control fast-mode bit |
| scl_low_cnt | output | CNT_W | SCL low count |
| scl_high_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |

## Verification
Several rules are checked on every cycle: the sticky event flags hold until a clear, the arrival of each event sets its flag, a full FIFO keeps its level when a write or push is refused, an empty receive FIFO stays empty under a pop, the levels stay within the depth, a disable empties both FIFOs, and the interrupt stays low while the mask is zero. Only the bench scenarios show the rest. These are the order of data through each FIFO, the exact threshold edges for both ready bits, readback truncation, the return of 0 on an empty read, and an event winning over a clear in the same cycle. They also show the interrupt following one enabled source.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

  // Word indices on the register bus (byte address >> 2)
  localparam logic [3:0] RG_CMD   = 4'd0;
  localparam logic [3:0] RG_RXD   = 4'd1;
  localparam logic [3:0] RG_CTL   = 4'd2;
  localparam logic [3:0] RG_IER   = 4'd3;
  localparam logic [3:0] RG_ISR   = 4'd4;
  localparam logic [3:0] RG_STAT  = 4'd5;
  localparam logic [3:0] RG_CLVL  = 4'd6;
  localparam logic [3:0] RG_RLVL  = 4'd7;
  localparam logic [3:0] RG_SLO   = 4'd8;
  localparam logic [3:0] RG_SHI   = 4'd9;
  localparam logic [3:0] RG_HOLD  = 4'd10;

  // Interrupt bit layout shared by mask and status
  localparam int IB_TX   = 0;
  localparam int IB_RX   = 1;
  localparam int IB_NACK = 2;
  localparam int IB_ARB  = 3;
  localparam int IB_OVF  = 4;
  localparam int NIRQ    = 5;

  localparam int CMD_W = 10;
  localparam int RX_W  = 8;

  typedef struct packed {
    logic [1:0] rx_thr;
    logic [1:0] cmd_thr;
    logic       fast;
    logic       en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Command room: level at or below threshold
  function automatic logic room_f(input logic [7:0] lvl, input logic [1:0] thr);
    return lvl <= {6'd0, thr};
  endfunction

  // Data waiting: level strictly above threshold
  function automatic logic avail_f(input logic [7:0] lvl, input logic [1:0] thr);
    return lvl > {6'd0, thr};
  endfunction

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          dropped
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign level   = count;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq
  import i2cf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            live_tx,
  input  logic            live_rx,
  input  logic            ev_nack,
  input  logic            ev_arb,
  input  logic            ev_ovf,
  input  logic [NIRQ-1:0] w1c,
  input  logic [NIRQ-1:0] ier,
  output logic [NIRQ-1:0] status,
  output logic            irq
);

  logic [NIRQ-1:0] ev_vec;
  logic [NIRQ-1:0] held;

  assign ev_vec = {ev_ovf, ev_arb, ev_nack, 2'b00};

  // Live level bits: no storage, follow the FIFO comparisons
  assign held[IB_TX] = live_tx;
  assign held[IB_RX] = live_rx;

  // Sticky event bits: set wins over a same-cycle clear
  for (genvar g = IB_NACK; g < NIRQ; g++) begin : g_sticky
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= ev_vec[g] | (bit_q & ~w1c[g]);
    end
    assign held[g] = bit_q;
  end

  assign status = held;
  assign irq    = |(status & ier);

endmodule

// File: rtl/i2cf_regs.sv
module i2cf_regs
  import i2cf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int LW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NIRQ-1:0]   status,
  input  logic [LW-1:0]     cmd_level,
  input  logic [LW-1:0]     rx_level,
  input  logic [RX_W-1:0]   rx_head,
  input  logic              rx_empty,
  input  logic              core_busy,
  output ctl_t              ctl,
  output logic [NIRQ-1:0]   ier,
  output logic [CNT_W-1:0]  scl_low,
  output logic [CNT_W-1:0]  scl_high,
  output logic [CNT_W-1:0]  sda_hold,
  output logic              cmd_push,
  output logic [CMD_W-1:0]  cmd_din,
  output logic              rx_pop,
  output logic [NIRQ-1:0]   w1c,
  output logic              flush
);

  logic       aligned;
  logic [3:0] word;
  logic       wr_hit, rd_hit;
  ctl_t       ctl_q;
  ctl_t       ctl_wr;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = 4'(bus_addr[ADDR_W-1:2]);
  assign wr_hit  = bus_wr && aligned;
  assign rd_hit  = bus_rd && aligned;
  assign ctl_wr  = ctl_t'(bus_wdata[CTL_W-1:0]);

  assign cmd_push = wr_hit && (word == RG_CMD);
  assign cmd_din  = bus_wdata[CMD_W-1:0];
  assign rx_pop   = rd_hit && (word == RG_RXD);
  assign w1c      = (wr_hit && (word == RG_ISR)) ? bus_wdata[NIRQ-1:0] : '0;
  assign flush    = wr_hit && (word == RG_CTL) && ctl_q.en && !ctl_wr.en;
  assign ctl      = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      ier      <= '0;
      scl_low  <= '0;
      scl_high <= '0;
      sda_hold <= '0;
    end else if (wr_hit) begin
      case (word)
        RG_CTL:  ctl_q    <= ctl_wr;
        RG_IER:  ier      <= bus_wdata[NIRQ-1:0];
        RG_SLO:  scl_low  <= bus_wdata[CNT_W-1:0];
        RG_SHI:  scl_high <= bus_wdata[CNT_W-1:0];
        RG_HOLD: sda_hold <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        RG_RXD:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
        RG_CTL:  bus_rdata = 32'(ctl_q);
        RG_IER:  bus_rdata = 32'(ier);
        RG_ISR:  bus_rdata = 32'(status);
        RG_STAT: bus_rdata = 32'(core_busy);
        RG_CLVL: bus_rdata = 32'(cmd_level);
        RG_RLVL: bus_rdata = 32'(rx_level);
        RG_SLO:  bus_rdata = 32'(scl_low);
        RG_SHI:  bus_rdata = 32'(scl_high);
        RG_HOLD: bus_rdata = 32'(sda_hold);
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/i2cm_csr_front.sv
module i2cm_csr_front
  import i2cf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              cmd_valid,
  output logic [9:0]        cmd_word,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              ev_nack,
  input  logic              ev_arb,
  input  logic              core_busy,
  output logic              core_en,
  output logic              fast_mode,
  output logic [CNT_W-1:0]  scl_low_cnt,
  output logic [CNT_W-1:0]  scl_high_cnt,
  output logic [CNT_W-1:0]  sda_hold_cnt
);

  localparam int LW = $clog2(DEPTH + 1);

  // Named internal events, also observed by the checker
  ctl_t            ctl;
  logic [NIRQ-1:0] ier;
  logic [NIRQ-1:0] status;
  logic [NIRQ-1:0] w1c;
  logic            flush;
  logic            cmd_push;
  logic [CMD_W-1:0] cmd_din;
  logic [LW-1:0]   cmd_level;
  logic            cmd_full, cmd_empty, cmd_dropped;
  logic            rx_pop;
  logic [RX_W-1:0] rx_head;
  logic [LW-1:0]   rx_level;
  logic            rx_full, rx_empty, rx_ovf;
  logic            live_tx, live_rx;

  i2cf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LW(LW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status    (status),
    .cmd_level (cmd_level),
    .rx_level  (rx_level),
    .rx_head   (rx_head),
    .rx_empty  (rx_empty),
    .core_busy (core_busy),
    .ctl       (ctl),
    .ier       (ier),
    .scl_low   (scl_low_cnt),
    .scl_high  (scl_high_cnt),
    .sda_hold  (sda_hold_cnt),
    .cmd_push  (cmd_push),
    .cmd_din   (cmd_din),
    .rx_pop    (rx_pop),
    .w1c       (w1c),
    .flush     (flush)
  );

  i2cf_fifo #(.W(CMD_W), .DEPTH(DEPTH), .LW(LW)) u_cmd_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (cmd_push),
    .din     (cmd_din),
    .pop     (cmd_pop),
    .dout    (cmd_word),
    .level   (cmd_level),
    .full    (cmd_full),
    .empty   (cmd_empty),
    .dropped (cmd_dropped)
  );

  i2cf_fifo #(.W(RX_W), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (rx_push),
    .din     (rx_byte),
    .pop     (rx_pop),
    .dout    (rx_head),
    .level   (rx_level),
    .full    (rx_full),
    .empty   (rx_empty),
    .dropped (rx_ovf)
  );

  assign live_tx = room_f(8'(cmd_level), ctl.cmd_thr);
  assign live_rx = avail_f(8'(rx_level), ctl.rx_thr);

  i2cf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .live_tx (live_tx),
    .live_rx (live_rx),
    .ev_nack (ev_nack),
    .ev_arb  (ev_arb),
    .ev_ovf  (rx_ovf),
    .w1c     (w1c),
    .ier     (ier),
    .status  (status),
    .irq     (irq)
  );

  assign cmd_valid = !cmd_empty;
  assign core_en   = ctl.en;
  assign fast_mode = ctl.fast;

endmodule

// File: rtl/i2cm_csr_front_chk.sv
module i2cm_csr_front_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3,
  parameter int NI    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [NI-1:0] ier,
  input logic [NI-1:0] status,
  input logic [NI-1:0] w1c,
  input logic          ev_nack,
  input logic          ev_arb,
  input logic          flush,
  input logic          cmd_push,
  input logic          cmd_pop,
  input logic [LW-1:0] cmd_level,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [LW-1:0] rx_level
);

  localparam logic [LW-1:0] FULLV = LW'(DEPTH);

  AST_NACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !w1c[2]) |=> status[2]);                                  // R10
  AST_ARB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !w1c[3]) |=> status[3]);                                  // R10
  AST_NACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> status[2]);                                                 // R10
  AST_ARB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |=> status[3]);                                                  // R10
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == FULLV && !rx_pop && !flush) |=> status[4]);     // R7
  AST_CMD_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && cmd_level == FULLV && !cmd_pop && !flush) |=> (cmd_level == FULLV)); // R4
  AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0 && !rx_push && !flush) |=> (rx_level == '0)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cmd_level == '0 && rx_level == '0));                         // R12
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |-> !irq);                                                  // R11
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_level <= FULLV && rx_level <= FULLV));                             // R5

endmodule

bind i2cm_csr_front i2cm_csr_front_chk #(.DEPTH(DEPTH), .LW(LW), .NI(i2cf_pkg::NIRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .ier       (ier),
  .status    (status),
  .w1c       (w1c),
  .ev_nack   (ev_nack),
  .ev_arb    (ev_arb),
  .flush     (flush),
  .cmd_push  (cmd_push),
  .cmd_pop   (cmd_pop),
  .cmd_level (cmd_level),
  .rx_push   (rx_push),
  .rx_pop    (rx_pop),
  .rx_level  (rx_level)
);

// File: tb/i2cm_csr_front_bench.sv
module i2cm_csr_front_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, cmd_valid;
  logic [9:0]  cmd_word;
  logic        cmd_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        ev_nack = 1'b0, ev_arb = 1'b0, core_busy = 1'b0;
  logic        core_en, fast_mode;
  logic [15:0] scl_low_cnt, scl_high_cnt, sda_hold_cnt;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  i2cm_csr_front u_i2cm_csr_front (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq),
    .cmd_valid (cmd_valid), .cmd_word (cmd_word), .cmd_pop (cmd_pop),
    .rx_push (rx_push), .rx_byte (rx_byte),
    .ev_nack (ev_nack), .ev_arb (ev_arb), .core_busy (core_busy),
    .core_en (core_en), .fast_mode (fast_mode),
    .scl_low_cnt (scl_low_cnt), .scl_high_cnt (scl_high_cnt),
    .sda_hold_cnt (sda_hold_cnt)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{6'h20, 32'h0000_1234, 32'h0000_1234},
    '{6'h24, 32'h0000_ABCD, 32'h0000_ABCD},
    '{6'h28, 32'h000F_0F0F, 32'h0000_0F0F},
    '{6'h0C, 32'h0000_00FF, 32'h0000_001F},
    '{6'h08, 32'hFFFF_FFFF, 32'h0000_003F},
    '{6'h08, 32'h0000_0001, 32'h0000_0001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rxp(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic popc();
    @(negedge clk);
    cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  exp_cmd [4];
    exp_cmd = '{10'h2A5, 10'h011, 10'h022, 10'h133};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(6'h08, r); check("R1 ctl", r, 32'h0);
    rd(6'h10, r); check("R1 status", r, 32'h1);
    rd(6'h20, r); check("R1 scl_low", r, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 cmd_valid", {31'd0, cmd_valid}, 32'h0);

    // R2: table of write/readback vectors
    for (int i = 0; i < 6; i++) begin
      wr(VT[i].a, VT[i].d);
      rd(VT[i].a, r);
      check("R2 readback", r, VT[i].e);
    end
    check("R2 scl_low port", 32'(scl_low_cnt), 32'h1234);
    check("R2 hold port", 32'(sda_hold_cnt), 32'h0F0F);
    check("R2 enable/fast ports", {30'd0, fast_mode, core_en}, 32'h1);
    // R11: command room live with full mask raises irq
    check("R11 irq tx room", {31'd0, irq}, 32'h1);
    wr(6'h0C, 32'h0);
    check("R11 irq masked", {31'd0, irq}, 32'h0);

    // R3 / R8: command path
    wr(6'h00, 32'h2A5);
    check("R3 cmd_valid", {31'd0, cmd_valid}, 32'h1);
    check("R3 cmd_word", 32'(cmd_word), 32'h2A5);
    rd(6'h18, r); check("R3 level 1", r, 32'd1);
    rd(6'h10, r); check("R8 room off at 1", r & 32'h1, 32'h0);
    wr(6'h00, 32'h011); wr(6'h00, 32'h022); wr(6'h00, 32'h133);
    rd(6'h18, r); check("R3 level 4", r, 32'd4);
    wr(6'h00, 32'h0FF);
    rd(6'h18, r); check("R4 level stays", r, 32'd4);
    for (int i = 0; i < 4; i++) begin
      check("R3 R4 order", 32'(cmd_word), 32'(exp_cmd[i]));
      popc();
    end
    check("R3 drained", {31'd0, cmd_valid}, 32'h0);
    rd(6'h10, r); check("R8 room on at 0", r & 32'h1, 32'h1);

    // R8 threshold 2, then R12 flush
    wr(6'h08, 32'h09);
    wr(6'h00, 32'h001); wr(6'h00, 32'h002);
    rd(6'h10, r); check("R8 room at thr", r & 32'h1, 32'h1);
    wr(6'h00, 32'h003);
    rd(6'h10, r); check("R8 room above thr", r & 32'h1, 32'h0);
    rxp(8'h77);
    wr(6'h08, 32'h08);
    rd(6'h18, r); check("R12 cmd flushed", r, 32'd0);
    rd(6'h1C, r); check("R12 rx flushed", r, 32'd0);
    wr(6'h08, 32'h01);

    // R5 / R9 / R6: receive path
    rxp(8'h5A);
    rd(6'h10, r); check("R9 avail at 1", (r >> 1) & 32'h1, 32'h1);
    wr(6'h10, 32'h02);
    rd(6'h10, r); check("R9 w1c ignored", (r >> 1) & 32'h1, 32'h1);
    wr(6'h08, 32'h11);
    rd(6'h10, r); check("R9 thr1 level1", (r >> 1) & 32'h1, 32'h0);
    rxp(8'h6B);
    rd(6'h10, r); check("R9 thr1 level2", (r >> 1) & 32'h1, 32'h1);
    rd(6'h1C, r); check("R5 level 2", r, 32'd2);
    rd(6'h04, r); check("R5 first", r, 32'h5A);
    rd(6'h04, r); check("R5 second", r, 32'h6B);
    rd(6'h04, r); check("R6 empty read", r, 32'h0);
    rd(6'h1C, r); check("R6 level 0", r, 32'd0);

    // R7: overrun
    wr(6'h08, 32'h01);
    for (int i = 0; i < 5; i++) rxp(8'(8'h11 + i));
    rd(6'h10, r); check("R7 ovf set", (r >> 4) & 32'h1, 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd(6'h04, r); check("R7 kept", r, 32'(8'h11 + i));
    end
    rd(6'h04, r); check("R7 fifth dropped", r, 32'h0);

    // R11: interrupt follows enabled overrun
    check("R11 irq none enabled", {31'd0, irq}, 32'h0);
    wr(6'h0C, 32'h10);
    check("R11 irq ovf", {31'd0, irq}, 32'h1);
    wr(6'h10, 32'h10);
    check("R11 irq after clear", {31'd0, irq}, 32'h0);
    wr(6'h0C, 32'h0);

    // R10: sticky events
    @(negedge clk); ev_nack = 1'b1;
    @(negedge clk); ev_nack = 1'b0;
    repeat (2) @(negedge clk);
    rd(6'h10, r); check("R10 nack sticky", (r >> 2) & 32'h1, 32'h1);
    wr(6'h10, 32'h04);
    rd(6'h10, r); check("R10 nack cleared", (r >> 2) & 32'h1, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h08; ev_arb = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_arb = 1'b0;
    rd(6'h10, r); check("R10 set beats clear", (r >> 3) & 32'h1, 32'h1);
    wr(6'h10, 32'h08);
    rd(6'h10, r); check("R10 arb cleared", (r >> 3) & 32'h1, 32'h0);

    // R13: busy readback
    core_busy = 1'b1;
    rd(6'h14, r); check("R13 busy", r, 32'h1);
    core_busy = 1'b0;
    rd(6'h14, r); check("R13 idle", r, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule